// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block runs one single-byte register read or write against an I2C target. It sits above a bit-level bus engine and sends that engine one command at a time: a start condition, a stop condition, a byte sent with an acknowledge sampled afterwards, a byte received with a not-acknowledge sent afterwards, or a bus recovery. It waits for the engine to report completion before it sends the next command. A request carries a direction, an 8-bit device address byte, an 8-bit register offset and, for writes, an 8-bit data byte. The response carries the read byte, one of three outcome flags and the number of attempts used.

A read is a random read. The block sends the address with the direction bit cleared, then the offset. It then issues a repeated start, sends the address with the direction bit set, and receives one byte, which it refuses with a not-acknowledge before the stop. A write sends the address, the offset and the data byte, then the stop. An attempt ends early on the first drive error or on a byte that was not acknowledged. After any failed attempt the block commands a bus recovery and waits a back-off counted in microsecond ticks. It then either retries or reports the failure. The retry limits for reads and for writes are separate parameters.

Top module: `i2c_regacc_ctrl`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `bb_en` is high from the cycle after acceptance up to, but not including, the response cycle, and every engine command is issued while `bb_en` is high.
- R2: The engine command codes are 0 = start, 1 = stop, 2 = send byte and sample acknowledge, 3 = receive byte and send not-acknowledge, 4 = bus recovery. A read attempt issues, in order: 0; 2 with the address and bit 0 cleared; 2 with the offset; 0; 2 with the address and bit 0 set; 3; 1.
- R3: A write attempt issues, in order: 0; 2 with the address and bit 0 cleared; 2 with the offset; 2 with the data byte; 1.
- R4: When a code-2 command completes with `eng_ack` low, the attempt is abandoned. The next command is code 4.
- R5: When any sequence command completes with `eng_drive_err` high, the attempt is abandoned. The next command is code 4.
- R6: After the recovery command completes, exactly `BACKOFF_US` pulses of `tick_us` pass before the next command or the response.
- R7: A read is attempted at most `RD_TRIES` times and a write at most `WR_TRIES` times. After the last failed attempt and its recovery and back-off, the block responds with `rsp_tries` equal to the limit.
- R8: On success `rsp_ok` is 1, both error flags are 0 and `rsp_tries` is the number of the attempt that succeeded. `rsp_data` is the received byte for a read and 0 for a write.
- R9: On failure `rsp_ok` is 0 and `rsp_data` is 0. Exactly one error flag is set, describing the last failed attempt: `rsp_drive_err` if the engine reported a drive error, which takes precedence over a missing acknowledge reported in the same completion, and `rsp_nack_err` otherwise.
- R10: `rsp_valid` is a one-cycle pulse in the cycle where `bb_en` falls.
- R11: After reset `req_ready` is 1 and `bb_en`, `rsp_valid` and `eng_cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_dev | input | 8 | Device address byte (bit 0 replaced by the direction) |
| req_off | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 8 | Read byte, zero otherwise |
| rsp_ok | output | 1 | Transaction succeeded |
| rsp_nack_err | output | 1 | Failed on missing acknowledge |
| rsp_drive_err | output | 1 | Failed on a drive error |
| rsp_tries | output | TRY_W | Attempts used |
| bb_en | output | 1 | Bus owned for bit-level control |
| eng_cmd_valid | output | 1 | Command strobe to the bit engine |
| eng_cmd | output | 3 | Command code |
| eng_cmd_byte | output | 8 | Byte for a send command |
| eng_done | input | 1 | Engine command complete |
| eng_ack | input | 1 | Target acknowledged the sent byte |
| eng_drive_err | input | 1 | Engine could not drive the line as asked |
| eng_rx_byte | input | 8 | Byte received by the engine |

## Verification
A wrong step index shows on the command port as a code or a byte out of order. This is visible at the next engine command, within a few cycles of the faulty completion. A failure that is misclassified, or a retry counter that slips, stays hidden until the response. There it shows as the wrong flag, a nonzero byte after a failure, or a wrong `rsp_tries`. A back-off counter that is off by one shows in the tick count between the completion of the recovery and the next command.

// File: rtl/i2c_regacc_pkg.sv
package i2c_regacc_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_WRB   = 3'd2,
    OP_RDN   = 3'd3,
    OP_RECOV = 3'd4
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_RISSUE, ST_RWAIT, ST_BACKOFF, ST_RESP
  } state_t;
endpackage

// File: rtl/i2c_regacc_seq.sv
module i2c_regacc_seq
  import i2c_regacc_pkg::*;
(
  input  logic       rd,
  input  logic [2:0] step,
  input  logic [7:0] dev,
  input  logic [7:0] off,
  input  logic [7:0] wdata,
  output op_t        op,
  output logic [7:0] byte_o,
  output logic       last
);
  logic [7:0] dev_w, dev_r;
  assign dev_w = {dev[7:1], 1'b0};
  assign dev_r = {dev[7:1], 1'b1};

  always_comb begin
    op     = OP_STOP;
    byte_o = 8'h00;
    last   = 1'b0;
    if (rd) begin
      case (step)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRB; byte_o = dev_w; end
        3'd2: begin op = OP_WRB; byte_o = off;   end
        3'd3: op = OP_START;
        3'd4: begin op = OP_WRB; byte_o = dev_r; end
        3'd5: op = OP_RDN;
        default: last = 1'b1;
      endcase
    end else begin
      case (step)
        3'd0: op = OP_START;
        3'd1: begin op = OP_WRB; byte_o = dev_w; end
        3'd2: begin op = OP_WRB; byte_o = off;   end
        3'd3: begin op = OP_WRB; byte_o = wdata; end
        default: last = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regacc_backoff.sv
module i2c_regacc_backoff #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && tick && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_regacc_ctrl.sv
module i2c_regacc_ctrl
  import i2c_regacc_pkg::*;
#(
  parameter int RD_TRIES   = 10,
  parameter int WR_TRIES   = 1,
  parameter int BACKOFF_US = 100000,
  localparam int MAX_TRIES = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES,
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rd,
  input  logic [7:0]       req_dev,
  input  logic [7:0]       req_off,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_ok,
  output logic             rsp_nack_err,
  output logic             rsp_drive_err,
  output logic [TRY_W-1:0] rsp_tries,
  output logic             bb_en,
  output logic             eng_cmd_valid,
  output logic [2:0]       eng_cmd,
  output logic [7:0]       eng_cmd_byte,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic             eng_drive_err,
  input  logic [7:0]       eng_rx_byte
);
  state_t           state_q, state_d;
  logic [2:0]       step_q, step_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic [7:0]       data_q, data_d;
  logic             ok_q, ok_d, nack_q, nack_d, drv_q, drv_d;
  logic             rd_q;
  logic [7:0]       dev_q, off_q, wd_q;
  logic             load;

  op_t        seq_op;
  logic [7:0] seq_byte;
  logic       seq_last;
  logic       bo_expire;
  logic       step_fail;
  logic [TRY_W-1:0] try_lim;

  i2c_regacc_seq u_seq (
    .rd(rd_q), .step(step_q), .dev(dev_q), .off(off_q), .wdata(wd_q),
    .op(seq_op), .byte_o(seq_byte), .last(seq_last)
  );

  i2c_regacc_backoff #(.LIMIT(BACKOFF_US)) u_backoff (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_BACKOFF),
    .tick(tick_us), .expire(bo_expire)
  );

  assign try_lim   = rd_q ? TRY_W'(RD_TRIES) : TRY_W'(WR_TRIES);
  assign step_fail = eng_drive_err || ((seq_op == OP_WRB) && !eng_ack);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    tries_d = tries_q;
    data_d  = data_q;
    ok_d    = ok_q;
    nack_d  = nack_q;
    drv_d   = drv_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        load    = 1'b1;
        step_d  = 3'd0;
        tries_d = TRY_W'(1);
        data_d  = 8'h00;
        ok_d    = 1'b0;
        nack_d  = 1'b0;
        drv_d   = 1'b0;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: if (eng_done) begin
        if (step_fail) begin
          data_d  = 8'h00;
          drv_d   = eng_drive_err;
          nack_d  = !eng_drive_err;
          state_d = ST_RISSUE;
        end else begin
          if (seq_op == OP_RDN) data_d = eng_rx_byte;
          if (seq_last) begin
            ok_d    = 1'b1;
            state_d = ST_RESP;
          end else begin
            step_d  = step_q + 3'd1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_RISSUE: state_d = ST_RWAIT;
      ST_RWAIT:  if (eng_done) state_d = ST_BACKOFF;
      ST_BACKOFF: if (bo_expire) begin
        if (tries_q == try_lim) begin
          state_d = ST_RESP;
        end else begin
          tries_d = tries_q + TRY_W'(1);
          step_d  = 3'd0;
          nack_d  = 1'b0;
          drv_d   = 1'b0;
          state_d = ST_ISSUE;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 3'd0;
      tries_q <= '0;
      data_q  <= 8'h00;
      ok_q    <= 1'b0;
      nack_q  <= 1'b0;
      drv_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      tries_q <= tries_d;
      data_q  <= data_d;
      ok_q    <= ok_d;
      nack_q  <= nack_d;
      drv_q   <= drv_d;
      if (load) rd_q <= req_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dev_q <= req_dev;
      off_q <= req_off;
      wd_q  <= req_wdata;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign bb_en         = (state_q != ST_IDLE) && (state_q != ST_RESP);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = data_q;
  assign rsp_ok        = ok_q;
  assign rsp_nack_err  = nack_q;
  assign rsp_drive_err = drv_q;
  assign rsp_tries     = tries_q;
  assign eng_cmd_valid = (state_q == ST_ISSUE) || (state_q == ST_RISSUE);
  assign eng_cmd       = (state_q == ST_RISSUE) ? OP_RECOV : seq_op;
  assign eng_cmd_byte  = (state_q == ST_RISSUE) ? 8'h00 : seq_byte;
endmodule

// File: rtl/i2c_regacc_chk.sv
module i2c_regacc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       bb_en,
  input logic       rsp_valid,
  input logic       rsp_ok,
  input logic       rsp_nack_err,
  input logic       rsp_drive_err,
  input logic [7:0] rsp_data,
  input logic       eng_cmd_valid
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bb_en);

  p_cmd_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> bb_en);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_en_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!bb_en && $past(bb_en)));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_nack_err, rsp_drive_err}) == 1));

  p_fail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_data == 8'h00));
endmodule

bind i2c_regacc_ctrl i2c_regacc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bb_en(bb_en),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_nack_err(rsp_nack_err),
  .rsp_drive_err(rsp_drive_err), .rsp_data(rsp_data),
  .eng_cmd_valid(eng_cmd_valid)
);

// File: tb/i2c_regacc_ctrl_bench.sv
module i2c_regacc_ctrl_bench;
  localparam int RDT = 10;
  localparam int WRT = 1;
  localparam int BO  = 20;

  logic clk, rst_n, tick_us;
  logic req_valid, req_ready, req_rd;
  logic [7:0] req_dev, req_off, req_wdata;
  logic rsp_valid, rsp_ok, rsp_nack_err, rsp_drive_err;
  logic [7:0] rsp_data;
  logic [3:0] rsp_tries;
  logic bb_en, eng_cmd_valid, eng_done, eng_ack, eng_drive_err;
  logic [2:0] eng_cmd;
  logic [7:0] eng_cmd_byte, eng_rx_byte;

  i2c_regacc_ctrl #(.RD_TRIES(RDT), .WR_TRIES(WRT), .BACKOFF_US(BO)) u_i2c_regacc_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_dev(req_dev), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
    .rsp_nack_err(rsp_nack_err), .rsp_drive_err(rsp_drive_err),
    .rsp_tries(rsp_tries), .bb_en(bb_en),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_cmd_byte(eng_cmd_byte),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_drive_err(eng_drive_err),
    .eng_rx_byte(eng_rx_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_run, n_fail;
  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [7:0] data; logic ok, nack, drv; int tries; } exp_t;
  exp_t exp_q[$];

  // Scenario state shared with the engine model
  bit cur_rd; logic [7:0] cur_dev, cur_off, cur_wd, cur_rx;
  int fail_n, fail_step, fail_kind; // kind: 0 nack, 1 drive, 2 both
  int att, stp; bit pend_fail;
  bit bo_arm; int tick_cnt;

  function automatic logic [10:0] exp_cmd(input bit rd, input int s);
    if (rd) begin
      case (s)
        0: return {3'd0, 8'h00};
        1: return {3'd2, cur_dev & 8'hFE};
        2: return {3'd2, cur_off};
        3: return {3'd0, 8'h00};
        4: return {3'd2, cur_dev | 8'h01};
        5: return {3'd3, 8'h00};
        default: return {3'd1, 8'h00};
      endcase
    end else begin
      case (s)
        0: return {3'd0, 8'h00};
        1: return {3'd2, cur_dev & 8'hFE};
        2: return {3'd2, cur_off};
        3: return {3'd2, cur_wd};
        default: return {3'd1, 8'h00};
      endcase
    end
  endfunction

  // Microsecond tick: one pulse every four cycles
  initial begin
    tick_us = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      #1 tick_us = 1'b1;
      @(posedge clk);
      #1 tick_us = 1'b0;
    end
  end

  // Bit engine model
  initial begin
    eng_done = 1'b0; eng_ack = 1'b0; eng_drive_err = 1'b0; eng_rx_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (eng_cmd_valid) begin
        logic [2:0] op; logic [7:0] b; bit fnow;
        op = eng_cmd; b = eng_cmd_byte; fnow = 1'b0;
        chk(bb_en, "R1 bb_en during command", bb_en, 1);
        if (op == 3'd4) begin
          chk(pend_fail, "R4/R5 recovery only after failure", 0, 1);
          pend_fail = 1'b0;
          att++; stp = 0;
        end else begin
          logic [10:0] e;
          e = exp_cmd(cur_rd, stp);
          chk(!pend_fail, "R4 R5 recovery must follow failure", op, 4);
          if (cur_rd) chk({op, b} == e, "R2 read command order", {op, b}, e);
          else        chk({op, b} == e, "R3 write command order", {op, b}, e);
          fnow = (att < fail_n) && (stp == fail_step);
          stp++;
        end
        repeat (2) @(posedge clk);
        #1;
        eng_done      = 1'b1;
        eng_ack       = !(fnow && fail_kind != 1);
        eng_drive_err = fnow && (fail_kind != 0);
        eng_rx_byte   = cur_rx;
        pend_fail     = fnow;
        @(posedge clk);
        #1;
        eng_done = 1'b0; eng_ack = 1'b0; eng_drive_err = 1'b0;
        if (op == 3'd4) begin tick_cnt = 0; bo_arm = 1'b1; end
      end
    end
  end

  // Response monitor and back-off tick counter
  bit prev_rsp;
  initial begin
    prev_rsp = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_rsp) chk(!rsp_valid, "R10 response single cycle", rsp_valid, 0);
      prev_rsp = rsp_valid;
      if (bo_arm) begin
        if (eng_cmd_valid || rsp_valid) begin
          chk(tick_cnt == BO, "R6 back-off tick count", tick_cnt, BO);
          bo_arm = 1'b0;
        end else if (tick_us) tick_cnt++;
      end
      if (rsp_valid) begin
        chk(!bb_en, "R10 bb_en low at response", bb_en, 0);
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_ok == e.ok, "R8/R9 ok flag", rsp_ok, e.ok);
          chk(rsp_nack_err == e.nack, "R9 nack flag", rsp_nack_err, e.nack);
          chk(rsp_drive_err == e.drv, "R9 drive flag", rsp_drive_err, e.drv);
          chk(rsp_data == e.data, "R8 R9 data", rsp_data, e.data);
          chk(int'(rsp_tries) == e.tries, "R7 attempts", rsp_tries, e.tries);
        end
      end
    end
  end

  task automatic run(input bit rd, input logic [7:0] dev, off, wd, rx,
                     input int fn, fs, fk);
    exp_t e; int lim;
    cur_rd = rd; cur_dev = dev; cur_off = off; cur_wd = wd; cur_rx = rx;
    fail_n = fn; fail_step = fs; fail_kind = fk;
    att = 0; stp = 0; pend_fail = 1'b0;
    lim = rd ? RDT : WRT;
    e.ok    = (fn < lim);
    e.tries = (fn < lim) ? fn + 1 : lim;
    e.data  = (e.ok && rd) ? rx : 8'h00;
    e.drv   = !e.ok && (fk != 0);
    e.nack  = !e.ok && (fk == 0);
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_rd = rd; req_dev = dev; req_off = off; req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready && !bb_en, "R1 idle after response", {req_ready, bb_en}, 2);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; bo_arm = 1'b0; tick_cnt = 0;
    req_valid = 1'b0; req_rd = 1'b0; req_dev = 8'h00; req_off = 8'h00; req_wdata = 8'h00;
    cur_rd = 1'b0; cur_dev = 0; cur_off = 0; cur_wd = 0; cur_rx = 0;
    fail_n = 0; fail_step = 0; fail_kind = 0; att = 0; stp = 0; pend_fail = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    chk(bb_en == 1'b0, "R11 reset bb_en", bb_en, 0);
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", rsp_valid, 0);
    chk(eng_cmd_valid == 1'b0, "R11 reset cmd_valid", eng_cmd_valid, 0);

    run(1, 8'hA0, 8'h10, 8'h00, 8'h5C, 0, 0, 0);   // R2 R8 clean read
    run(0, 8'hA1, 8'h22, 8'h3C, 8'h77, 0, 0, 0);   // R3 R8 clean write, bit 0 forced low
    run(1, 8'h50, 8'h07, 8'h00, 8'hC3, 2, 2, 0);   // R4 R6 offset nack twice, then success
    run(1, 8'hA2, 8'h01, 8'h00, 8'h11, 12, 4, 0);  // R7 R9 read nack every attempt
    run(0, 8'hA4, 8'h30, 8'h99, 8'h00, 1, 3, 0);   // R4 R7 write data nack, single attempt
    run(1, 8'hA6, 8'h44, 8'h00, 8'hEE, 10, 6, 1);  // R5 R9 drive error at stop, data cleared
    run(0, 8'hA8, 8'h55, 8'h66, 8'h00, 1, 1, 2);   // R9 both reported, drive wins
    run(1, 8'hFF, 8'hFF, 8'h00, 8'hFF, 9, 0, 1);   // R5 R7 start drive error, last attempt ok

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule